// File: doc/BRIEF.md
# PHY bring-up and link sequencer

This controller takes an Ethernet PHY from power-up to a known link state. It talks to the PHY only through a management-register request port, of the kind an MDIO master serves. One request is outstanding at a time. A pulse on `start` begins the run. The sequencer then holds the active-low PHY reset pin low for a programmed number of milliseconds. After that it scans the 32 management addresses for a responding PHY and reads the link status at the address it found.

When the link is already up, the run ends there. When the link is down, the sequencer writes a soft reset and waits for it to clear. It then enables auto-negotiation and restarts it, and polls link status at a fixed millisecond spacing until link comes up or the poll budget runs out. Millisecond timing comes from a prescaler that counts clock cycles. Both the prescaler period and the poll limits are parameters, so a simulation can shorten the waits.

The run ends with exactly one of three results: success, no PHY found, or soft reset stuck. A link that never came up still reports success, with a separate timeout warning set.

Top module: `phy_linkup_seq`

## Requirements
- R1: After synchronous reset, `busy`, `ok`, `err_absent`, `err_softrst`, `warn_timeout` and `req_valid` are 0, `found_addr` is 0 and `phy_rst_n` is 1.
- R2: When `start` is high while the block is idle, `busy` is 1 on the next cycle. `phy_rst_n` is then held low for RESET_MS*TICKS_PER_MS cycles, or at most two cycles more, and no request is issued while it is low. A `start` pulse while `busy` is 1 has no effect on the sequence.
- R3: After the reset pulse, register 0 is read at addresses 0, 1, 2 and upward. The first address whose read data has bit 15 equal to 0 is chosen and shown on `found_addr`.
- R4: If all 32 addresses return bit 15 set, the run ends with `err_absent`.
- R5: Register 1 is then read at the chosen address. If bit 2 of the data is 1, the run ends with `ok` and no write is issued. Other bits of the data are ignored.
- R6: If the link bit is 0, the block writes 0x8000 to register 0. It then reads register 0 up to SOFT_POLLS times, stopping at the first read with bit 15 clear. If no read comes back clear, the run ends with `err_softrst`.
- R7: After the soft reset clears, the block writes 0x1300 to register 0. That value sets bits 12 (auto-negotiation enable), 9 (restart) and 8 (full duplex). It then reads register 1, with at least LINK_WAIT_MS*TICKS_PER_MS cycles between the start of one read and the start of the next. The run ends with `ok` at the first read with bit 2 set.
- R8: If LINK_POLLS reads of register 1 all show bit 2 clear, the run ends with both `ok` and `warn_timeout` set.
- R9: `req_valid` and the request fields stay unchanged until `req_done`. `req_valid` is 0 in the cycle after `req_done`, so at most one request is outstanding at a time.
- R10: `busy` stays 1 until it falls on the same edge that sets exactly one of `ok`, `err_absent` or `err_softrst`. The result flags then hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the bring-up sequence (accepted only when idle) |
| phy_rst_n | output | 1 | Active-low PHY hardware reset |
| req_valid | output | 1 | Management request pending |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data |
| req_done | input | 1 | One-cycle completion pulse from the management master |
| req_rdata | input | 16 | Read data, valid with `req_done` |
| busy | output | 1 | Sequence in progress |
| found_addr | output | 5 | Address of the discovered PHY |
| ok | output | 1 | Sequence completed |
| err_absent | output | 1 | No PHY responded |
| err_softrst | output | 1 | Soft reset bit never cleared |
| warn_timeout | output | 1 | Link did not come up within the poll budget |

## Verification
The timing of each result is fixed. `busy` is high one cycle after an accepted `start`. The reset pin stays low for RESET_MS*TICKS_PER_MS+1 cycles, because the prescaler restarts when the timer loads. Each new request appears two cycles after the `req_done` that ended the one before it, and the result flags change on the same edge that consumes the last `req_done`. The bench samples everything at the falling clock edge. A monitor compares each request when `req_valid` rises against a queue of expected requests, filled in advance from the scenario. The final flags are checked once `busy` is seen low, and again five cycles later to confirm they hold. The spacing between link polls is measured in cycles, and the length of the reset pulse is checked within a window two cycles wide.

// File: rtl/phy_linkup_pkg.sv
package phy_linkup_pkg;
  localparam int PHY_ADDR_W = 5;
  localparam int REG_ADDR_W = 5;
  localparam int MGMT_DATA_W = 16;

  localparam logic [REG_ADDR_W-1:0]  REG_CTRL = 5'd0;
  localparam logic [REG_ADDR_W-1:0]  REG_STAT = 5'd1;
  localparam int                     CTRL_RESET_BIT = 15;
  localparam int                     STAT_LINK_BIT  = 2;
  localparam logic [MGMT_DATA_W-1:0] CTRL_SOFT_RESET = 16'h8000;
  localparam logic [MGMT_DATA_W-1:0] CTRL_ANEG_GO    = 16'h1300;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HWRST, ST_SCAN, ST_LINK0, ST_SRST_WR,
    ST_SRST_POLL, ST_ANEG_WR, ST_LINK_POLL, ST_LINK_WAIT
  } seq_state_t;
endpackage

// File: rtl/phy_tick_gen.sv
module phy_tick_gen #(
  parameter int TICKS_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end

  assign tick = (pcnt == LAST);
endmodule

// File: rtl/phy_ms_timer.sv
module phy_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (load) remain <= load_val;
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import phy_linkup_pkg::*;
#(
  parameter int TICKS_PER_MS = 250000,
  parameter int RESET_MS     = 15,
  parameter int SOFT_POLLS   = 10,
  parameter int LINK_POLLS   = 5000,
  parameter int LINK_WAIT_MS = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        phy_rst_n,
  output logic        req_valid,
  output logic        req_write,
  output logic [4:0]  req_addr,
  output logic [4:0]  req_reg,
  output logic [15:0] req_wdata,
  input  logic        req_done,
  input  logic [15:0] req_rdata,
  output logic        busy,
  output logic [4:0]  found_addr,
  output logic        ok,
  output logic        err_absent,
  output logic        err_softrst,
  output logic        warn_timeout
);
  localparam int MS_MAX = (RESET_MS > LINK_WAIT_MS) ? RESET_MS : LINK_WAIT_MS;
  localparam int TMR_W  = $clog2(MS_MAX + 1);
  localparam int PL_MAX = (SOFT_POLLS > LINK_POLLS) ? SOFT_POLLS : LINK_POLLS;
  localparam int PC_W   = $clog2(PL_MAX + 1);
  localparam logic [PHY_ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [PC_W-1:0] SOFT_LAST = PC_W'(SOFT_POLLS - 1);
  localparam logic [PC_W-1:0] LINK_LAST = PC_W'(LINK_POLLS - 1);

  seq_state_t             state;
  logic [PHY_ADDR_W-1:0]  scan_addr;
  logic [PC_W-1:0]        poll_cnt;
  logic                   tmr_load, tmr_expired, ms_tick;
  logic [TMR_W-1:0]       tmr_val;
  logic                   rsp;

  assign rsp = req_valid && req_done;

  // Load the millisecond timer when entering the reset pulse or a link-poll wait
  assign tmr_load = (state == ST_IDLE && start) ||
                    (state == ST_LINK_POLL && rsp && !req_rdata[STAT_LINK_BIT] &&
                     poll_cnt != LINK_LAST);
  assign tmr_val  = (state == ST_IDLE) ? TMR_W'(RESET_MS) : TMR_W'(LINK_WAIT_MS);

  phy_tick_gen #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .restart(tmr_load), .tick(ms_tick)
  );

  phy_ms_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(ms_tick), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      phy_rst_n    <= 1'b1;
      req_valid    <= 1'b0;
      req_write    <= 1'b0;
      req_addr     <= '0;
      req_reg      <= '0;
      req_wdata    <= '0;
      busy         <= 1'b0;
      found_addr   <= '0;
      ok           <= 1'b0;
      err_absent   <= 1'b0;
      err_softrst  <= 1'b0;
      warn_timeout <= 1'b0;
      scan_addr    <= '0;
      poll_cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          busy         <= 1'b1;
          ok           <= 1'b0;
          err_absent   <= 1'b0;
          err_softrst  <= 1'b0;
          warn_timeout <= 1'b0;
          found_addr   <= '0;
          phy_rst_n    <= 1'b0;
          state        <= ST_HWRST;
        end
        ST_HWRST: if (tmr_expired) begin
          phy_rst_n <= 1'b1;
          scan_addr <= '0;
          state     <= ST_SCAN;
        end
        ST_SCAN: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b0;
            req_addr  <= scan_addr; req_reg <= REG_CTRL; req_wdata <= '0;
          end else if (req_done) begin
            req_valid <= 1'b0;
            if (!req_rdata[CTRL_RESET_BIT]) begin
              found_addr <= scan_addr;
              state      <= ST_LINK0;
            end else if (scan_addr == LAST_ADDR) begin
              err_absent <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              scan_addr <= scan_addr + 1'b1;
            end
          end
        end
        ST_LINK0: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b0;
            req_addr  <= found_addr; req_reg <= REG_STAT; req_wdata <= '0;
          end else if (req_done) begin
            req_valid <= 1'b0;
            if (req_rdata[STAT_LINK_BIT]) begin
              ok <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              state <= ST_SRST_WR;
            end
          end
        end
        ST_SRST_WR: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b1;
            req_addr  <= found_addr; req_reg <= REG_CTRL; req_wdata <= CTRL_SOFT_RESET;
          end else if (req_done) begin
            req_valid <= 1'b0;
            poll_cnt  <= '0;
            state     <= ST_SRST_POLL;
          end
        end
        ST_SRST_POLL: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b0;
            req_addr  <= found_addr; req_reg <= REG_CTRL; req_wdata <= '0;
          end else if (req_done) begin
            req_valid <= 1'b0;
            if (!req_rdata[CTRL_RESET_BIT]) begin
              state <= ST_ANEG_WR;
            end else if (poll_cnt == SOFT_LAST) begin
              err_softrst <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end
        ST_ANEG_WR: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b1;
            req_addr  <= found_addr; req_reg <= REG_CTRL; req_wdata <= CTRL_ANEG_GO;
          end else if (req_done) begin
            req_valid <= 1'b0;
            poll_cnt  <= '0;
            state     <= ST_LINK_POLL;
          end
        end
        ST_LINK_POLL: begin
          if (!req_valid) begin
            req_valid <= 1'b1; req_write <= 1'b0;
            req_addr  <= found_addr; req_reg <= REG_STAT; req_wdata <= '0;
          end else if (req_done) begin
            req_valid <= 1'b0;
            if (req_rdata[STAT_LINK_BIT]) begin
              ok <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
            end else if (poll_cnt == LINK_LAST) begin
              ok <= 1'b1; warn_timeout <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              state    <= ST_LINK_WAIT;
            end
          end
        end
        ST_LINK_WAIT: if (tmr_expired) state <= ST_LINK_POLL;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_linkup_chk.sv
module phy_linkup_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        phy_rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [4:0]  req_addr,
  input logic [4:0]  req_reg,
  input logic [15:0] req_wdata,
  input logic        req_done,
  input logic        busy,
  input logic        ok,
  input logic        err_absent,
  input logic        err_softrst,
  input logic        warn_timeout
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_no_req_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_n |-> !req_valid);

  assert_reset_pin_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_n |-> busy);

  assert_write_values_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (req_reg == 5'd0 &&
      (req_wdata == 16'h8000 || req_wdata == 16'h1300)));

  assert_warn_with_ok_R8: assert property (@(posedge clk) disable iff (rst)
    warn_timeout |-> ok);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_done) |=> (req_valid && $stable(req_write) &&
      $stable(req_addr) && $stable(req_reg) && $stable(req_wdata)));

  assert_req_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_done) |=> !req_valid);

  assert_one_result_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($countones({ok, err_absent, err_softrst}) == 1));

  assert_flags_clear_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(ok || err_absent || err_softrst || warn_timeout));
endmodule

bind phy_linkup_seq phy_linkup_chk u_chk (.*);

// File: tb/phy_linkup_seq_tb.sv
`timescale 1ns/1ps
module phy_linkup_seq_tb;
  localparam int TPM = 4, RMS = 3, SP = 10, LP = 4, LWM = 2;

  typedef struct packed {
    logic       we;
    logic [4:0] a;
    logic [4:0] r;
    logic [15:0] d;
  } req_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic phy_rst_n, req_valid, req_write, req_done, busy;
  logic ok, err_absent, err_softrst, warn_timeout;
  logic [4:0] req_addr, req_reg, found_addr;
  logic [15:0] req_wdata, req_rdata;

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  req_t  expq[$];
  string tagq[$];

  int m_phy = -1, m_srst_need = 0, m_link_after = -1, m_srst_left = 0, m_link_reads = 0;
  bit m_link_init = 0, m_aneg = 0;

  always #2 clk = ~clk;

  phy_linkup_seq #(.TICKS_PER_MS(TPM), .RESET_MS(RMS), .SOFT_POLLS(SP),
                   .LINK_POLLS(LP), .LINK_WAIT_MS(LWM)) u_dut (
    .clk(clk), .rst(rst), .start(start), .phy_rst_n(phy_rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_done(req_done),
    .req_rdata(req_rdata), .busy(busy), .found_addr(found_addr), .ok(ok),
    .err_absent(err_absent), .err_softrst(err_softrst), .warn_timeout(warn_timeout)
  );

  task automatic check(input bit good, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_access(req_t q);
    if (q.we) begin
      if (int'(q.a) == m_phy && q.r == 5'd0) begin
        if (q.d == 16'h8000) m_srst_left = m_srst_need;
        else if (q.d == 16'h1300) begin m_aneg = 1; m_link_reads = 0; end
      end
      return 16'h0000;
    end
    if (m_phy < 0 || int'(q.a) != m_phy) return 16'hFFFF;
    if (q.r == 5'd0) begin
      if (m_srst_left > 0) begin m_srst_left--; return 16'h8000; end
      return 16'h7FFF;
    end
    if (!m_aneg) return m_link_init ? 16'h0004 : 16'hFFFB;
    m_link_reads++;
    return (m_link_after >= 0 && m_link_reads > m_link_after) ? 16'h0004 : 16'hFFFB;
  endfunction

  // Responder: completes each request three falling edges after it appears
  initial begin
    int lat;
    req_t cur;
    lat = 0;
    req_done = 1'b0;
    req_rdata = '0;
    forever begin
      @(negedge clk);
      if (req_done) req_done = 1'b0;
      else if (req_valid && !rst) begin
        if (lat == 0) cur = {req_write, req_addr, req_reg, req_wdata};
        lat++;
        if (lat == 3) begin
          check(cur == {req_write, req_addr, req_reg, req_wdata}, "R9",
                "request fields held until done", {req_write, req_addr, req_reg, req_wdata}, cur);
          req_rdata = model_access(cur);
          req_done  = 1'b1;
          lat = 0;
        end
      end
    end
  end

  // Monitor: compares each new request with the scoreboard queue
  initial begin
    bit prev;
    bit lphase;
    int low;
    longint last_lp;
    req_t got, e;
    string tg;
    prev = 0; lphase = 0; low = 0; last_lp = -1;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!phy_rst_n) low++;
        else if (low != 0) begin
          check(low >= RMS*TPM && low <= RMS*TPM + 2, "R2", "reset pulse cycles", low, RMS*TPM + 1);
          low = 0;
        end
        if (req_valid && !prev) begin
          got = {req_write, req_addr, req_reg, req_wdata};
          if (expq.size() == 0) check(0, "R3", "unexpected request", got, 0);
          else begin
            e  = expq.pop_front();
            tg = tagq.pop_front();
            check(got == e, tg, "request order/content", got, e);
          end
          if (got.we && got.d == 16'h1300) begin lphase = 1; last_lp = -1; end
          else if (!got.we && got.r == 5'd0) lphase = 0;
          else if (lphase && !got.we && got.r == 5'd1) begin
            if (last_lp >= 0)
              check(cyc - last_lp >= LWM*TPM, "R7", "link poll spacing", cyc - last_lp, LWM*TPM);
            last_lp = cyc;
          end
        end
        prev = req_valid;
      end
    end
  end

  initial forever begin @(posedge clk); cyc++; end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic push(input bit we, input int a, input int r, input logic [15:0] d, input string tg);
    expq.push_back({we, 5'(a), 5'(r), d});
    tagq.push_back(tg);
  endtask

  task automatic run_case(input int phy, input bit link_init, input int srst_need,
                          input int link_after, input bit poke);
    int nscan, np, nl;
    bit e_abs, e_srst, e_ok, e_warn;
    e_abs = 0; e_srst = 0; e_ok = 0; e_warn = 0;
    nscan = (phy < 0) ? 32 : phy + 1;
    for (int i = 0; i < nscan; i++) push(0, i, 0, 16'h0, "R3");
    if (phy < 0) e_abs = 1;
    else begin
      push(0, phy, 1, 16'h0, "R5");
      if (link_init) e_ok = 1;
      else begin
        push(1, phy, 0, 16'h8000, "R6");
        np = (srst_need >= SP) ? SP : srst_need + 1;
        for (int i = 0; i < np; i++) push(0, phy, 0, 16'h0, "R6");
        if (srst_need >= SP) e_srst = 1;
        else begin
          push(1, phy, 0, 16'h1300, "R7");
          e_warn = (link_after < 0 || link_after >= LP);
          nl = e_warn ? LP : link_after + 1;
          for (int i = 0; i < nl; i++) push(0, phy, 1, 16'h0, e_warn ? "R8" : "R7");
          e_ok = 1;
        end
      end
    end
    m_phy = phy; m_link_init = link_init; m_srst_need = srst_need;
    m_link_after = link_after; m_aneg = 0; m_srst_left = 0; m_link_reads = 0;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check({ok, err_absent, err_softrst, warn_timeout} == 4'b0, "R10", "flags cleared by start",
          {ok, err_absent, err_softrst, warn_timeout}, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(expq.size() == 0, "R3", "expected requests left over", expq.size(), 0);
    expq.delete(); tagq.delete();
    if (phy >= 0) check(found_addr == 5'(phy), "R3", "found_addr", found_addr, phy);
    check(err_absent == e_abs, "R4", "err_absent", err_absent, e_abs);
    check(err_softrst == e_srst, "R6", "err_softrst", err_softrst, e_srst);
    check(ok == e_ok, "R5", "ok", ok, e_ok);
    check(warn_timeout == e_warn, "R8", "warn_timeout", warn_timeout, e_warn);
    check($countones({ok, err_absent, err_softrst}) == 1, "R10", "single result",
          $countones({ok, err_absent, err_softrst}), 1);
    repeat (5) @(negedge clk);
    check({ok, err_absent, err_softrst, warn_timeout} == {e_ok, e_abs, e_srst, e_warn} && !busy,
          "R10", "flags hold after finish", {ok, err_absent, err_softrst, warn_timeout},
          {e_ok, e_abs, e_srst, e_warn});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy, ok, err_absent, err_softrst, warn_timeout, req_valid} == 6'b0 &&
          phy_rst_n && found_addr == 5'd0, "R1", "reset state",
          {busy, ok, err_absent, err_softrst, warn_timeout, req_valid, phy_rst_n}, 1);
    run_case(5,  1, 0, -1, 0);   // link already up, no writes
    run_case(0,  0, 2, 2,  1);   // soft reset clears, link up on 3rd poll; stray start ignored
    run_case(-1, 0, 0, -1, 0);   // no PHY anywhere
    run_case(3,  0, 50, -1, 0);  // soft reset never clears
    run_case(31, 0, 0, -1, 0);   // last address, link never comes up
    run_case(7,  0, 9, 3,  0);   // clears on last allowed poll, link on last allowed poll
    run_case(31, 1, 0, -1, 0);   // last address with link up
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule